// File: doc/BRIEF.md
# Byte Read-Modify-Write Memory Initiator

This block is a small accelerator that walks a fixed run of consecutive bytes in external memory. Software first sets a base pointer through a memory-mapped register port that behaves like an AXI4-Lite target. It then writes a start bit. For every byte of the run, the block issues a single-beat AXI4 read, adds a constant to the returned byte, and writes the sum back to the same address with one single-beat AXI4 write. Software polls a status word until the done bit appears.

Memory ordering is strict. The next location is not read until the write response for the current one has arrived. An error bit records any response that is not OKAY, and the run still completes.

The sequencer is one state machine with five states:
- `S_IDLE`: waits for start.
- `S_RD_ADDR`: holds the read address valid.
- `S_RD_DATA`: waits for the read beat.
- `S_WR_REQ`: drives the write address and the write data, each until it is accepted.
- `S_WR_RESP`: waits for the write response.

Its transitions are:
- `S_IDLE` to `S_RD_ADDR` on an accepted start.
- `S_RD_ADDR` to `S_RD_DATA` on the read-address handshake.
- `S_RD_DATA` to `S_WR_REQ` on the read-data beat.
- `S_WR_REQ` to `S_WR_RESP` once both the address and the data have been taken.
- `S_WR_RESP` to `S_RD_ADDR` on a write response, when more bytes remain.
- `S_WR_RESP` to `S_IDLE` on the final write response.

Top module: `byte_rmw_engine`

## Requirements
- R1: After reset, the status word reads 0, and none of ARVALID, AWVALID or WVALID on the memory side is asserted.
- R2: The register map uses the target address bits [3:2]. Word 0 is control and status: writing bit0=1 requests a start, and reading gives bit0 busy, bit1 done and bit2 error. Word 1 holds the base pointer and reads back the last value written. Other words read as 0. Every target response is OKAY (2'b00).
- R3: One run replaces each byte at addresses base to base+9 with (old value + 3) mod 256. The bytes at base-1 and base+10 are left unchanged.
- R4: Each run issues exactly 10 reads and 10 writes. Every one is a single-beat transaction with LEN=0, SIZE=0 (one byte), BURST=INCR (2'b01) and WLAST=1. The i-th read and the i-th write both use address base+i.
- R5: WSTRB has only bit addr[1:0] set. The sum travels in that byte lane of WDATA, and the read byte is taken from RDATA bits [8*addr[1:0]+7 : 8*addr[1:0]].
- R6: The read for byte i+1 is issued only after the write response for byte i. The write for byte i is issued only after its read data has returned.
- R7: The done bit sets after the last write response. It clears when the next start is accepted.
- R8: Any RRESP or BRESP other than 2'b00 sets the error bit. The bit then stays set until the next accepted start, and the run still writes all 10 bytes.
- R9: A start written while busy is ignored. The base pointer is captured at start, so rewriting it during a run does not change that run's addresses.
- R10: Addresses wrap modulo 2^32, so a run that starts near the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 4 | Target write address |
| s_awvalid | input | 1 | Target write address valid |
| s_awready | output | 1 | Target write address ready |
| s_wdata | input | 32 | Target write data |
| s_wvalid | input | 1 | Target write data valid |
| s_wready | output | 1 | Target write data ready |
| s_bresp | output | 2 | Target write response |
| s_bvalid | output | 1 | Target write response valid |
| s_bready | input | 1 | Target write response ready |
| s_araddr | input | 4 | Target read address |
| s_arvalid | input | 1 | Target read address valid |
| s_arready | output | 1 | Target read address ready |
| s_rdata | output | 32 | Target read data |
| s_rresp | output | 2 | Target read response |
| s_rvalid | output | 1 | Target read data valid |
| s_rready | input | 1 | Target read data ready |
| m_araddr | output | 32 | Memory read address |
| m_arlen | output | 8 | Memory read burst length, always 0 |
| m_arsize | output | 3 | Memory read size, always one byte |
| m_arburst | output | 2 | Memory read burst type, INCR |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_rdata | input | 32 | Memory read data |
| m_rresp | input | 2 | Memory read response |
| m_rlast | input | 1 | Memory read last beat |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |
| m_awaddr | output | 32 | Memory write address |
| m_awlen | output | 8 | Memory write burst length, always 0 |
| m_awsize | output | 3 | Memory write size, always one byte |
| m_awburst | output | 2 | Memory write burst type, INCR |
| m_awvalid | output | 1 | Memory write address valid |
| m_awready | input | 1 | Memory write address ready |
| m_wdata | output | 32 | Memory write data |
| m_wstrb | output | 4 | Memory write byte strobes |
| m_wlast | output | 1 | Memory write last beat, always 1 |
| m_wvalid | output | 1 | Memory write data valid |
| m_wready | input | 1 | Memory write data ready |
| m_bresp | input | 2 | Memory write response |
| m_bvalid | input | 1 | Memory write response valid |
| m_bready | output | 1 | Memory write response ready |

## Verification
The bench sweeps base pointers over all four lane offsets. The sweep includes runs that cross a word boundary, the edge of the modelled memory and the top of the address space, with byte values near 255 so that the add must wrap:
- A wrong byte lane would corrupt a neighbouring byte or add to the wrong value.
- A missing address wrap would leave an address mismatch at the base+i check.

The memory model stalls AR, AW and W independently and varies its read latency. This exposes two ordering faults:
- A design that overlaps a read with the preceding write's response breaks the ordering check.
- A design that waits for both channels in the same cycle would hang.

Further cases target the status bits and the start path:
- Error responses are injected on one read and, separately, on one write. A non-sticky error bit, or a run aborted early, shows up in the status word or in memory.
- A second start and a base rewrite are sent mid-run. If either took effect, the read count would exceed 10 or wrong bytes would be touched.

// File: rtl/byte_rmw_pkg.sv
package byte_rmw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ADDR,
        S_RD_DATA,
        S_WR_REQ,
        S_WR_RESP
    } rmw_state_e;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;

    // word index of target registers (address bits [3:2])
    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_BASE = 1;

endpackage

// File: rtl/byte_rmw_regs.sv
module byte_rmw_regs
    import byte_rmw_pkg::*;
#(
    parameter int CSR_AW = 4,
    parameter int CSR_DW = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [CSR_DW-1:0] s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [CSR_AW-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [CSR_DW-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              err_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] base_o
);
    localparam int SEL_W = CSR_AW - 2;

    logic              wr_go, rd_go, start_acc;
    logic [SEL_W-1:0]  wsel, rsel;
    logic              done_q, err_q, start_q;
    logic [ADDR_W-1:0] base_q;
    logic              unused_lowbits;

    assign unused_lowbits = ^{s_awaddr[1:0], s_araddr[1:0]};
    assign wsel      = s_awaddr[CSR_AW-1:2];
    assign rsel      = s_araddr[CSR_AW-1:2];
    assign wr_go     = s_awvalid && s_wvalid && !s_bvalid;
    assign s_awready = s_wvalid && !s_bvalid;
    assign s_wready  = s_awvalid && !s_bvalid;
    assign rd_go     = s_arvalid && !s_rvalid;
    assign s_arready = !s_rvalid;
    assign s_bresp   = RESP_OKAY;
    assign s_rresp   = RESP_OKAY;
    assign start_o   = start_q;
    assign base_o    = base_q;
    assign start_acc = start_q && !busy_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_bvalid <= 1'b0;
            start_q  <= 1'b0;
            base_q   <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else begin
            start_q <= wr_go && (wsel == SEL_W'(REG_CTRL)) && s_wdata[0];
            if (wr_go) begin
                s_bvalid <= 1'b1;
                if (wsel == SEL_W'(REG_BASE))
                    base_q <= s_wdata[ADDR_W-1:0];
            end else if (s_bvalid && s_bready) begin
                s_bvalid <= 1'b0;
            end
            if (done_i)
                done_q <= 1'b1;
            else if (start_acc)
                done_q <= 1'b0;
            if (err_i)
                err_q <= 1'b1;
            else if (start_acc)
                err_q <= 1'b0;
            if (rd_go) begin
                s_rvalid <= 1'b1;
                if (rsel == SEL_W'(REG_CTRL))
                    s_rdata <= CSR_DW'({err_q, done_q, busy_i});
                else if (rsel == SEL_W'(REG_BASE))
                    s_rdata <= CSR_DW'(base_q);
                else
                    s_rdata <= '0;
            end else if (s_rvalid && s_rready) begin
                s_rvalid <= 1'b0;
            end
        end
    end

    // R7: an accepted start leaves done cleared in the next cycle
    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc && !done_i |=> !done_q);

    // R8: error stays set until a start is accepted
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !start_acc |=> err_q);

    // R2: a target read response is held until taken
    p_rresp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

endmodule

// File: rtl/byte_rmw_seq.sv
module byte_rmw_seq
    import byte_rmw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int RUN_LEN = 10,
    parameter int ADD_VAL = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   base_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [7:0]          m_arlen,
    output logic [2:0]          m_arsize,
    output logic [1:0]          m_arburst,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rlast,
    input  logic                m_rvalid,
    output logic                m_rready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready
);
    localparam int STRB_W = DATA_W / 8;
    localparam int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1;
    localparam int CNT_W  = $clog2(RUN_LEN + 1);
    localparam logic [7:0]       INC      = 8'(ADD_VAL);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RUN_LEN - 1);

    rmw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q;
    logic [7:0]        byte_q;
    logic              aw_sent_q, w_sent_q;
    logic [LANE_W-1:0] lane;
    logic              aw_fin, w_fin, last_item;
    logic              unused_rlast;

    assign unused_rlast = m_rlast;
    assign lane      = addr_q[LANE_W-1:0];
    assign aw_fin    = aw_sent_q || (m_awvalid && m_awready);
    assign w_fin     = w_sent_q || (m_wvalid && m_wready);
    assign last_item = (idx_q == LAST_IDX);

    // fixed single-beat transaction attributes
    assign m_araddr  = addr_q;
    assign m_awaddr  = addr_q;
    assign m_arlen   = 8'd0;
    assign m_awlen   = 8'd0;
    assign m_arsize  = 3'd0;
    assign m_awsize  = 3'd0;
    assign m_arburst = BURST_INCR;
    assign m_awburst = BURST_INCR;
    assign m_wlast   = 1'b1;
    assign m_wdata   = {STRB_W{byte_q + INC}};
    assign m_wstrb   = STRB_W'(1) << lane;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i)          state_d = S_RD_ADDR;
            S_RD_ADDR: if (m_arready)        state_d = S_RD_DATA;
            S_RD_DATA: if (m_rvalid)         state_d = S_WR_REQ;
            S_WR_REQ:  if (aw_fin && w_fin)  state_d = S_WR_RESP;
            S_WR_RESP: if (m_bvalid)         state_d = last_item ? S_IDLE : S_RD_ADDR;
            default:                         state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        m_awvalid = 1'b0;
        m_wvalid  = 1'b0;
        m_bready  = 1'b0;
        done_o    = 1'b0;
        err_o     = 1'b0;
        busy_o    = 1'b1;
        unique case (state_q)
            S_IDLE:    busy_o = 1'b0;
            S_RD_ADDR: m_arvalid = 1'b1;
            S_RD_DATA: begin
                m_rready = 1'b1;
                err_o    = m_rvalid && (m_rresp != RESP_OKAY);
            end
            S_WR_REQ: begin
                m_awvalid = !aw_sent_q;
                m_wvalid  = !w_sent_q;
            end
            S_WR_RESP: begin
                m_bready = 1'b1;
                done_o   = m_bvalid && last_item;
                err_o    = m_bvalid && (m_bresp != RESP_OKAY);
            end
            default: busy_o = 1'b0;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            idx_q     <= '0;
            byte_q    <= '0;
            aw_sent_q <= 1'b0;
            w_sent_q  <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                addr_q <= base_i;
                idx_q  <= '0;
            end
            if (state_q == S_RD_DATA && m_rvalid)
                byte_q <= m_rdata[{lane, 3'b000} +: 8];
            if (state_q == S_WR_REQ) begin
                if (aw_fin && w_fin) begin
                    aw_sent_q <= 1'b0;
                    w_sent_q  <= 1'b0;
                end else begin
                    aw_sent_q <= aw_fin;
                    w_sent_q  <= w_fin;
                end
            end
            if (state_q == S_WR_RESP && m_bvalid) begin
                addr_q <= addr_q + ADDR_W'(1);
                idx_q  <= idx_q + CNT_W'(1);
            end
        end
    end

    // R4: a read request is held with a stable address until accepted
    p_ar_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

    // R4: a write request is held with a stable address until accepted
    p_aw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

    // R6: no read is outstanding while a write is being issued or answered
    p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> !m_awvalid && !m_wvalid && !m_bready);

    // R5: exactly one byte lane enabled per write beat
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> $countones(m_wstrb) == 1);

    // R7: after the final response the sequencer is idle
    p_done_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/byte_rmw_engine.sv
module byte_rmw_engine
    import byte_rmw_pkg::*;
#(
    parameter int CSR_AW  = 4,
    parameter int CSR_DW  = 32,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int RUN_LEN = 10,
    parameter int ADD_VAL = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CSR_AW-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [CSR_DW-1:0]   s_wdata,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [CSR_AW-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [CSR_DW-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [7:0]          m_arlen,
    output logic [2:0]          m_arsize,
    output logic [1:0]          m_arburst,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rlast,
    input  logic                m_rvalid,
    output logic                m_rready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready
);
    logic              start_w, busy_w, done_w, err_w;
    logic [ADDR_W-1:0] base_w;

    byte_rmw_regs #(
        .CSR_AW(CSR_AW), .CSR_DW(CSR_DW), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .busy_i(busy_w), .done_i(done_w), .err_i(err_w),
        .start_o(start_w), .base_o(base_w)
    );

    byte_rmw_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RUN_LEN(RUN_LEN), .ADD_VAL(ADD_VAL)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_w), .base_i(base_w),
        .busy_o(busy_w), .done_o(done_w), .err_o(err_w),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
        .m_rvalid(m_rvalid), .m_rready(m_rready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

endmodule

// File: tb/byte_rmw_engine_tb.sv
module byte_rmw_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0]  s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic        s_bready = 1'b1, s_rready = 1'b1;
    logic [31:0] s_wdata = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;

    logic [31:0] m_araddr, m_awaddr, m_wdata;
    logic [7:0]  m_arlen, m_awlen;
    logic [2:0]  m_arsize, m_awsize;
    logic [1:0]  m_arburst, m_awburst;
    logic        m_arvalid, m_rready, m_awvalid, m_wvalid, m_wlast, m_bready;
    logic [3:0]  m_wstrb;
    logic        mem_arready, mem_awready, mem_wready;
    logic        mem_rvalid, mem_bvalid;
    logic [31:0] mem_rdata;
    logic [1:0]  mem_rresp, mem_bresp;

    byte_rmw_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(mem_arready),
        .m_rdata(mem_rdata), .m_rresp(mem_rresp), .m_rlast(1'b1),
        .m_rvalid(mem_rvalid), .m_rready(m_rready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(mem_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(mem_wready),
        .m_bresp(mem_bresp), .m_bvalid(mem_bvalid), .m_bready(m_bready)
    );

    // ---------------- memory model (64 bytes, address mod 64) ----------------
    logic [7:0]  mem [0:63];
    logic        init_go = 1'b0;
    logic [7:0]  init_seed = '0;
    logic [31:0] cur_base = '0;
    int          rd_err_at = -1, wr_err_at = -1;
    int          ar_cnt, r_cnt, aw_cnt, b_cnt;
    int          viol_addr, viol_lane, viol_order;
    logic [3:0]  tick;
    logic        rd_pend, aw_have, w_have;
    logic [1:0]  rd_wait;
    logic [31:0] rd_addr, aw_addr_q, w_data_q;
    logic [3:0]  w_strb_q;
    logic [1:0]  rd_resp_q;

    function automatic logic [7:0] pat(input int j, input logic [7:0] seed);
        return 8'((j * 37 + seed) & 255);
    endfunction

    assign mem_arready = !rd_pend && !mem_rvalid && (tick[0] ^ tick[1]);
    assign mem_awready = !aw_have && !mem_bvalid && tick[1];
    assign mem_wready  = !w_have && !mem_bvalid && (tick[0] | tick[2]);

    always @(posedge clk) begin
        tick <= tick + 4'd1;
        if (!rst_n || init_go) begin
            if (init_go)
                for (int j = 0; j < 64; j++) mem[j] <= pat(j, init_seed);
            rd_pend <= 1'b0; aw_have <= 1'b0; w_have <= 1'b0;
            mem_rvalid <= 1'b0; mem_bvalid <= 1'b0;
            ar_cnt <= 0; r_cnt <= 0; aw_cnt <= 0; b_cnt <= 0;
            viol_addr <= 0; viol_lane <= 0; viol_order <= 0;
            if (!rst_n) tick <= '0;
        end else begin
            if (m_arvalid && mem_arready) begin
                rd_addr <= m_araddr;
                rd_pend <= 1'b1;
                rd_wait <= 2'(ar_cnt * 3);
                rd_resp_q <= (ar_cnt == rd_err_at) ? 2'b10 : 2'b00;
                ar_cnt <= ar_cnt + 1;
                if (m_araddr != cur_base + 32'(ar_cnt) || m_arlen != 0 ||
                    m_arsize != 0 || m_arburst != 2'b01)
                    viol_addr <= viol_addr + 1;
                if (b_cnt != ar_cnt) viol_order <= viol_order + 1;
            end
            if (rd_pend) begin
                if (rd_wait == 0) begin
                    rd_pend <= 1'b0;
                    mem_rvalid <= 1'b1;
                    mem_rresp <= rd_resp_q;
                    for (int k = 0; k < 4; k++)
                        mem_rdata[8*k +: 8] <= mem[{rd_addr[5:2], 2'(k)}];
                end else begin
                    rd_wait <= rd_wait - 2'd1;
                end
            end
            if (mem_rvalid && m_rready) begin
                mem_rvalid <= 1'b0;
                r_cnt <= r_cnt + 1;
            end
            if (m_awvalid && mem_awready) begin
                aw_have <= 1'b1;
                aw_addr_q <= m_awaddr;
                aw_cnt <= aw_cnt + 1;
                if (r_cnt != aw_cnt + 1) viol_order <= viol_order + 1;
                if (m_awlen != 0 || m_awsize != 0 || m_awburst != 2'b01)
                    viol_addr <= viol_addr + 1;
            end
            if (m_wvalid && mem_wready) begin
                w_have <= 1'b1;
                w_data_q <= m_wdata;
                w_strb_q <= m_wstrb;
                if (!m_wlast) viol_addr <= viol_addr + 1;
                if (r_cnt != b_cnt + 1) viol_order <= viol_order + 1;
            end
            if (aw_have && w_have && !mem_bvalid) begin
                aw_have <= 1'b0; w_have <= 1'b0;
                mem_bvalid <= 1'b1;
                mem_bresp <= (b_cnt == wr_err_at) ? 2'b10 : 2'b00;
                for (int k = 0; k < 4; k++)
                    if (w_strb_q[k]) mem[{aw_addr_q[5:2], 2'(k)}] <= w_data_q[8*k +: 8];
                if (w_strb_q != (4'b0001 << aw_addr_q[1:0])) viol_lane <= viol_lane + 1;
                if (aw_addr_q != cur_base + 32'(b_cnt)) viol_addr <= viol_addr + 1;
            end
            if (mem_bvalid && m_bready) begin
                mem_bvalid <= 1'b0;
                b_cnt <= b_cnt + 1;
            end
        end
    end

    // ---------------- checking ----------------
    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic csr_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
    endtask

    task automatic csr_read(input logic [3:0] a, output logic [31:0] d,
                            output logic [1:0] r);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        d = s_rdata; r = s_rresp;
    endtask

    task automatic run_one(input logic [31:0] base, input logic [7:0] seed,
                           input int rerr, input int werr, input bit disturb,
                           input string tag);
        logic [31:0] st;
        logic [1:0]  rr;
        bit          exp_err;
        @(negedge clk);
        init_seed = seed; cur_base = base; rd_err_at = rerr; wr_err_at = werr;
        init_go = 1'b1;
        @(negedge clk);
        init_go = 1'b0;
        exp_err = (rerr >= 0) || (werr >= 0);
        csr_write(4'h4, base);
        csr_write(4'h0, 32'h1);
        csr_read(4'h0, st, rr);
        chk(st[1:0] == 2'b01, "R7", {tag, " done cleared, busy after start"}, st[1:0], 2'b01);
        if (disturb) begin
            csr_write(4'h4, base + 32'd20);
            csr_write(4'h0, 32'h1);
        end
        for (int n = 0; n < 400; n++) begin
            csr_read(4'h0, st, rr);
            if (st[1]) break;
        end
        chk(st[2:0] == {exp_err, 2'b10}, "R8", {tag, " status after run"},
            st[2:0], {exp_err, 2'b10});
        chk(ar_cnt == 10 && b_cnt == 10, "R4", {tag, " read/write counts"},
            ar_cnt * 100 + b_cnt, 1010);
        chk(viol_addr == 0, (base > 32'hFFFF_FF00) ? "R10" : "R4",
            {tag, " address/attribute violations"}, viol_addr, 0);
        chk(viol_lane == 0, "R5", {tag, " strobe lane violations"}, viol_lane, 0);
        chk(viol_order == 0, "R6", {tag, " ordering violations"}, viol_order, 0);
        for (int i = 0; i < 10; i++) begin
            int j;
            j = int'((base + 32'(i)) & 32'd63);
            chk(mem[j] == 8'(pat(j, seed) + 8'd3), "R3", {tag, " byte updated"},
                mem[j], 8'(pat(j, seed) + 8'd3));
        end
        begin
            int lo, hi;
            lo = int'((base - 32'd1) & 32'd63);
            hi = int'((base + 32'd10) & 32'd63);
            chk(mem[lo] == pat(lo, seed), "R3", {tag, " byte below untouched"}, mem[lo], pat(lo, seed));
            chk(mem[hi] == pat(hi, seed), "R3", {tag, " byte above untouched"}, mem[hi], pat(hi, seed));
        end
        if (disturb) begin
            csr_read(4'h4, st, rr);
            chk(st == base + 32'd20, "R9", {tag, " base rewrite stored"}, st, base + 32'd20);
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [1:0]  r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs and status after reset
        chk(!m_arvalid && !m_awvalid && !m_wvalid, "R1", "memory valids after reset",
            {m_arvalid, m_awvalid, m_wvalid}, 0);
        csr_read(4'h0, d, r);
        chk(d == 0, "R1", "status after reset", d, 0);
        // R2: register map
        csr_write(4'h4, 32'h1234_5678);
        csr_read(4'h4, d, r);
        chk(d == 32'h1234_5678, "R2", "base readback", d, 32'h1234_5678);
        chk(r == 2'b00, "R2", "target read response", r, 0);
        csr_read(4'h8, d, r);
        chk(d == 0, "R2", "unmapped word reads zero", d, 0);
        chk(s_bresp == 2'b00, "R2", "target write response", s_bresp, 0);
        // R3/R5 sweep over lane offsets and word crossings
        for (int b = 0; b < 8; b++)
            run_one(32'(b), 8'(b * 29 + 200), -1, -1, 1'b0, "sweep");
        run_one(32'h0000_003C, 8'hF0, -1, -1, 1'b0, "edge64");
        // R10: address space wrap
        run_one(32'hFFFF_FFFA, 8'hFD, -1, -1, 1'b0, "wrap");
        // R8: read error, then write error, then clean run clears
        run_one(32'h0000_0011, 8'h10, 4, -1, 1'b0, "rderr");
        run_one(32'h0000_0013, 8'h22, -1, 9, 1'b0, "wrerr");
        run_one(32'h0000_0002, 8'h33, -1, -1, 1'b0, "clean");
        // R9: start and base rewrite during a run
        run_one(32'h0000_0006, 8'hFE, -1, -1, 1'b1, "busy");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule